// File: doc/BRIEF.md
# Three-Level Descriptor DMA Address Sequencer

This block steps through one transfer descriptor and produces the source and destination addresses of a three-level transfer. A transfer is made of arrays of ACNT bytes. BCNT arrays form a frame, and CCNT frames form the whole transfer. The descriptors sit in a small parameter RAM of `N_SLOTS` slots, each eight 32-bit words wide. Slot 0 is the active slot that the sequencer works on. The other slots hold descriptors that can be loaded into slot 0 when a transfer finishes.

Software writes descriptors through a word-wide configuration port and can read any word back. Each pulse on `trig` serves part of the transfer:
- In array-synchronized mode a trigger serves one array.
- In frame-synchronized mode a trigger serves a whole frame.

Each array becomes one request on a valid/ack address port. After the service, the updated addresses and counts are written back to slot 0. When the last frame finishes, slot 0 is either replaced by the linked slot or has its counts cleared. Interrupt and chain pulses carrying a 6-bit completion code report intermediate and final completion.

Top module: `dma3d_sequencer`

## Requirements
- R1: After reset, `busy`, `req_valid`, `trig_err`, `cmp_int`, `cmp_chain` and `cmp_final` are low, and every RAM word reads zero.
- R2: When options bit 2 is 0 (array sync), a trigger issues exactly one request. It carries the current source, destination and ACNT (A/B word bits 15:0). The request stays stable until `req_ack`.
- R3: When options bit 2 is 1 (frame sync), a trigger issues BCNT (A/B word bits 31:16) requests back to back. The stored BCNT is the same value before and after the frame.
- R4: Address update for an address in incrementing mode (source: options bit 0 = 0; destination: bit 1 = 0):
  - after an array that is not the last of its frame, it adds the signed B stride;
  - after the last array of a frame, it adds the signed C stride instead.
  - Strides are word 4 (B) and word 6 (C); the source uses bits 15:0 and the destination bits 31:16.
  - With the mode bit at 1 the address never changes, and `req_src_const`/`req_dst_const` show the bits.
- R5: After each service of a non-static descriptor (options bit 3 = 0) that is not final:
  - source (word 1) and destination (word 3) of slot 0 hold the next addresses;
  - BCNT holds the remaining count; in array sync it is reloaded from word 5 bits 31:16 after a frame ends;
  - CCNT (word 7 bits 15:0) holds the frames left.
- R6: When the final frame of a non-static descriptor completes and the link (word 5 bits 15:0) names an existing slot, all eight words of that slot are copied into slot 0.
- R7: When the link is 0xFFFF or any value that names no slot, final completion leaves the following in slot 0, and `busy` falls:
  - the updated addresses;
  - word 2 zero;
  - word 7 bits 15:0 zero.
- R8: A static descriptor (options bit 3 = 1) is never written by the sequencer, so a later trigger repeats the same addresses.
- R9: Completion pulses for a service with completion enables set:
  - a one-cycle `cmp_int` pulse fires for a final service when options bit 20 is set, or for an intermediate service when bit 21 is set;
  - `cmp_chain` follows the same rule with bits 22 and 23;
  - `cmp_final` marks final completion;
  - `cmp_code` carries options bits 17:12.
- R10: With options bit 11 at 0, the completion pulse appears two cycles after the cycle of the service's last acked request. With bit 11 at 1 (early mode) it appears one cycle after.
- R11: A trigger arriving while ACNT, BCNT or CCNT of slot 0 is zero gives a one-cycle `trig_err` pulse and no request.
- R12: A trigger arriving during a service is held and served afterwards. At most one is held, and further triggers during that service are dropped.
- R13: `req_beat_bytes` is 2 to the power of the width code in options bits 10:8 for codes 0 to 5, and 0 for codes 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write one RAM word |
| cfg_slot | input | $clog2(N_SLOTS) | Slot for the write |
| cfg_word | input | 3 | Word index within the slot |
| cfg_wdata | input | 32 | Write data |
| rd_slot | input | $clog2(N_SLOTS) | Slot for read-back |
| rd_word | input | 3 | Word index for read-back |
| rd_data | output | 32 | Read-back data (combinational) |
| trig | input | 1 | Transfer trigger pulse |
| req_valid | output | 1 | An array request is presented |
| req_ack | input | 1 | The request is taken |
| req_src | output | 32 | Source address of the array |
| req_dst | output | 32 | Destination address of the array |
| req_bytes | output | 16 | Bytes in the array |
| req_beat_bytes | output | 6 | Bytes per beat from the width code |
| req_src_const | output | 1 | Source uses constant addressing |
| req_dst_const | output | 1 | Destination uses constant addressing |
| busy | output | 1 | A trigger is being served |
| trig_err | output | 1 | Trigger refused because a count is zero |
| cmp_int | output | 1 | Completion interrupt pulse |
| cmp_chain | output | 1 | Completion chain pulse |
| cmp_final | output | 1 | The pulse reports final completion |
| cmp_code | output | 6 | Completion code for the pulse |

## Verification
The hardest case to reach is the held trigger, because a service normally ends within a few cycles of starting. The bench holds `req_ack` low so the first service stalls on its request. While it is stalled, the bench fires two more triggers, then releases the ack. It then checks that exactly one extra service ran and that the second held trigger left no trace. The same stalled descriptor finishes its last frame with an out-of-range link, which shows the null-link clearing with a link value other than 0xFFFF. Early-mode timing is measured against the cycle of the last acked request rather than against the trigger.

// File: rtl/dma3d_pkg.sv
// Shared constants and helpers for the three-level DMA sequencer.
// Assumes eight 32-bit words per descriptor; word and bit positions
// below are decoded by the sequencer and must not move.
package dma3d_pkg;
    localparam int DESC_WORDS = 8;

    // Word positions inside one descriptor
    localparam int W_OPT  = 0;
    localparam int W_SRC  = 1;
    localparam int W_AB   = 2;
    localparam int W_DST  = 3;
    localparam int W_BSTR = 4;
    localparam int W_LINK = 5;
    localparam int W_CSTR = 6;
    localparam int W_CCNT = 7;

    // Bit positions inside the options word
    localparam int B_SRC_CONST = 0;
    localparam int B_DST_CONST = 1;
    localparam int B_FRAME_SYNC = 2;
    localparam int B_STATIC = 3;
    localparam int B_EARLY = 11;
    localparam int B_INT_FINAL = 20;
    localparam int B_INT_MID = 21;
    localparam int B_CHN_FINAL = 22;
    localparam int B_CHN_MID = 23;

    typedef logic [31:0] word_t;
    typedef logic [DESC_WORDS-1:0][31:0] desc_t;

    typedef enum logic [1:0] {S_IDLE, S_REQ, S_WB} seq_state_t;

    // Bytes per beat for a width code; reserved codes give zero
    function automatic logic [5:0] beat_bytes(input logic [2:0] code);
        beat_bytes = (code <= 3'd5) ? (6'd1 << code) : 6'd0;
    endfunction
endpackage

// File: rtl/dma3d_param_ram.sv
// Descriptor storage: N_SLOTS slots of eight words held in flops.
// Offers a word write/read port for software, a full-slot view of the
// active slot 0 and of the linked slot, and a full-slot write of slot 0
// for the sequencer. The sequencer write wins over a software write to slot 0.
module dma3d_param_ram
    import dma3d_pkg::*;
#(
    parameter int N_SLOTS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [$clog2(N_SLOTS)-1:0] cfg_slot,
    input  logic [2:0]                 cfg_word,
    input  word_t                      cfg_wdata,
    input  logic [$clog2(N_SLOTS)-1:0] rd_slot,
    input  logic [2:0]                 rd_word,
    output word_t                      rd_data,
    input  logic [$clog2(N_SLOTS)-1:0] link_slot,
    output desc_t                      link_desc,
    output desc_t                      act_desc,
    input  logic                       seq_we,
    input  desc_t                      seq_desc
);
    localparam int SLOT_W = $clog2(N_SLOTS);

    desc_t slots [N_SLOTS];

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        desc_t slot_q;
        // Hold one slot; slot 0 also accepts the sequencer write-back
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (s == 0 && seq_we) begin
                slot_q <= seq_desc;
            end else if (cfg_we && cfg_slot == SLOT_W'(s)) begin
                slot_q[cfg_word] <= cfg_wdata;
            end
        end
        assign slots[s] = slot_q;
    end

    assign rd_data   = slots[rd_slot][rd_word];
    assign link_desc = slots[link_slot];
    assign act_desc  = slots[0];
endmodule

// File: rtl/dma3d_addr_step.sv
// Next-address logic for one direction. Adds the sign-extended B stride
// inside a frame and the C stride at a frame end; constant mode holds.
// Assumes two's-complement wrap of the 32-bit address.
module dma3d_addr_step (
    input  logic [31:0] addr,
    input  logic        hold,
    input  logic        frame_end,
    input  logic [15:0] b_stride,
    input  logic [15:0] c_stride,
    output logic [31:0] next
);
    logic [15:0] stride;

    // Pick the stride for this step and apply it unless held
    always_comb begin
        stride = frame_end ? c_stride : b_stride;
        next   = hold ? addr : addr + {{16{stride[15]}}, stride};
    end
endmodule

// File: rtl/dma3d_trig_queue.sv
// Trigger acceptance with one held trigger. A trigger seen while the
// sequencer is busy is remembered once; extra ones are dropped.
// Assumes `idle` is high exactly when a new service may begin.
module dma3d_trig_queue (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic idle,
    output logic start,
    output logic pend
);
    assign start = idle && (trig || pend);

    // Keep at most one trigger for after the current service
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (idle) begin
            pend <= pend && trig;
        end else begin
            pend <= pend || trig;
        end
    end

    assert_trig_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        trig && !idle |=> pend);
endmodule

// File: rtl/dma3d_cmp_events.sv
// Completion pulse generator. On a completion strobe it raises the
// interrupt and chain pulses enabled in the options word for the kind of
// completion, with the 6-bit code. All outputs are registered.
module dma3d_cmp_events
    import dma3d_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  logic       is_final,
    input  word_t      opt,
    output logic       cmp_int,
    output logic       cmp_chain,
    output logic       cmp_final,
    output logic [5:0] cmp_code
);
    logic want_int, want_chain;
    logic opt_unused;

    assign want_int   = fire && (is_final ? opt[B_INT_FINAL] : opt[B_INT_MID]);
    assign want_chain = fire && (is_final ? opt[B_CHN_FINAL] : opt[B_CHN_MID]);
    assign opt_unused = ^{opt[31:24], opt[19:18], opt[11:0]};

    // Register one-cycle completion pulses and their code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_int   <= 1'b0;
            cmp_chain <= 1'b0;
            cmp_final <= 1'b0;
            cmp_code  <= '0;
        end else begin
            cmp_int   <= want_int;
            cmp_chain <= want_chain;
            cmp_final <= (want_int || want_chain) && is_final;
            cmp_code  <= (want_int || want_chain) ? opt[17:12] : 6'd0;
        end
    end

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_int || cmp_chain) |=> !(cmp_int || cmp_chain));
endmodule

// File: rtl/dma3d_sequencer.sv
// Three-level DMA address sequencer. Serves slot 0 of the descriptor RAM:
// one array per trigger (array sync) or one frame per trigger (frame sync).
// Each array is one valid/ack request. After each service the next state is
// written back to slot 0, or on final completion the linked slot is copied
// in or the counts are cleared. Assumes software does not write slot 0
// while busy is high.
module dma3d_sequencer
    import dma3d_pkg::*;
#(
    parameter int N_SLOTS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [$clog2(N_SLOTS)-1:0] cfg_slot,
    input  logic [2:0]                 cfg_word,
    input  logic [31:0]                cfg_wdata,
    input  logic [$clog2(N_SLOTS)-1:0] rd_slot,
    input  logic [2:0]                 rd_word,
    output logic [31:0]                rd_data,
    input  logic                       trig,
    output logic                       req_valid,
    input  logic                       req_ack,
    output logic [31:0]                req_src,
    output logic [31:0]                req_dst,
    output logic [15:0]                req_bytes,
    output logic [5:0]                 req_beat_bytes,
    output logic                       req_src_const,
    output logic                       req_dst_const,
    output logic                       busy,
    output logic                       trig_err,
    output logic                       cmp_int,
    output logic                       cmp_chain,
    output logic                       cmp_final,
    output logic [5:0]                 cmp_code
);
    localparam int SLOT_W = $clog2(N_SLOTS);
    localparam int N_DIR = 2;   // 0 = source, 1 = destination

    seq_state_t state;
    desc_t act, link_desc, wb_desc;
    word_t opt;
    logic [N_DIR-1:0][31:0] addr_q, addr_nx;
    logic [15:0] bcnt_q, ccnt_q;
    logic fin_q, err_q;
    logic start, pend, idle;
    logic [15:0] acnt, bcnt, ccnt, rld, link_val;
    logic zero_cnt, frame_end, last_arr, svc_end, link_ok, ack_go, seq_we;
    logic fire, fire_final;

    assign opt       = act[W_OPT];
    assign acnt      = act[W_AB][15:0];
    assign bcnt      = act[W_AB][31:16];
    assign ccnt      = act[W_CCNT][15:0];
    assign rld       = act[W_LINK][31:16];
    assign link_val  = act[W_LINK][15:0];
    assign zero_cnt  = (acnt == 16'd0) || (bcnt == 16'd0) || (ccnt == 16'd0);
    assign frame_end = (bcnt_q == 16'd1);
    assign last_arr  = frame_end && (ccnt_q == 16'd1);
    assign svc_end   = !opt[B_FRAME_SYNC] || frame_end;
    assign link_ok   = link_val < 16'(N_SLOTS);
    assign idle      = (state == S_IDLE);
    assign ack_go    = (state == S_REQ) && req_ack;
    assign seq_we    = (state == S_WB) && !opt[B_STATIC];

    dma3d_param_ram #(.N_SLOTS(N_SLOTS)) u_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_slot  (cfg_slot),
        .cfg_word  (cfg_word),
        .cfg_wdata (cfg_wdata),
        .rd_slot   (rd_slot),
        .rd_word   (rd_word),
        .rd_data   (rd_data),
        .link_slot (link_val[SLOT_W-1:0]),
        .link_desc (link_desc),
        .act_desc  (act),
        .seq_we    (seq_we),
        .seq_desc  (wb_desc)
    );

    dma3d_trig_queue u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (trig),
        .idle  (idle),
        .start (start),
        .pend  (pend)
    );

    // One address stepper per direction; stride halves split by direction
    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        dma3d_addr_step u_step (
            .addr      (addr_q[d]),
            .hold      (opt[d]),
            .frame_end (frame_end),
            .b_stride  (act[W_BSTR][16*d +: 16]),
            .c_stride  (act[W_CSTR][16*d +: 16]),
            .next      (addr_nx[d])
        );
    end

    // Service state machine: load, request arrays, then write back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            addr_q <= '0;
            bcnt_q <= '0;
            ccnt_q <= '0;
            fin_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start && zero_cnt) begin
                        err_q <= 1'b1;
                    end else if (start) begin
                        addr_q[0] <= act[W_SRC];
                        addr_q[1] <= act[W_DST];
                        bcnt_q    <= bcnt;
                        ccnt_q    <= ccnt;
                        state     <= S_REQ;
                    end
                end
                S_REQ: begin
                    if (req_ack) begin
                        addr_q <= addr_nx;
                        if (frame_end) begin
                            ccnt_q <= ccnt_q - 16'd1;
                            bcnt_q <= opt[B_FRAME_SYNC] ? bcnt : rld;
                        end else begin
                            bcnt_q <= bcnt_q - 16'd1;
                        end
                        if (svc_end) begin
                            fin_q <= last_arr;
                            state <= S_WB;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Build the slot 0 image written at the end of a service
    always_comb begin
        wb_desc         = act;
        wb_desc[W_SRC]  = addr_q[0];
        wb_desc[W_DST]  = addr_q[1];
        wb_desc[W_AB]   = fin_q ? 32'd0 : {bcnt_q, acnt};
        wb_desc[W_CCNT] = {act[W_CCNT][31:16], fin_q ? 16'd0 : ccnt_q};
        if (fin_q && link_ok) begin
            wb_desc = link_desc;
        end
    end

    // Completion strobe: at the last ack in early mode, else at write-back
    assign fire       = opt[B_EARLY] ? (ack_go && svc_end) : (state == S_WB);
    assign fire_final = opt[B_EARLY] ? last_arr : fin_q;

    dma3d_cmp_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .is_final  (fire_final),
        .opt       (opt),
        .cmp_int   (cmp_int),
        .cmp_chain (cmp_chain),
        .cmp_final (cmp_final),
        .cmp_code  (cmp_code)
    );

    assign req_valid      = (state == S_REQ);
    assign req_src        = addr_q[0];
    assign req_dst        = addr_q[1];
    assign req_bytes      = acnt;
    assign req_beat_bytes = beat_bytes(opt[10:8]);
    assign req_src_const  = opt[B_SRC_CONST];
    assign req_dst_const  = opt[B_DST_CONST];
    assign busy           = !idle;
    assign trig_err       = err_q;

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ack |=> req_valid && $stable(req_src) && $stable(req_dst));

    assert_err_no_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        trig_err |-> !req_valid);

    assert_null_link_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WB) && fin_q && !link_ok && !opt[B_STATIC]
        |=> !busy && (act[W_AB] == 32'd0) && (act[W_CCNT][15:0] == 16'd0));

    assert_static_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WB) && opt[B_STATIC] && !cfg_we |=> $stable(act));
endmodule

// File: tb/dma3d_sequencer_bench.sv
// Scoreboard bench: a model task pushes expected requests and completion
// events into queues; a monitor pops and compares as the design produces them.
module dma3d_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_slot = '0;
    logic [2:0]  cfg_word = '0;
    logic [31:0] cfg_wdata = '0;
    logic [2:0]  rd_slot = '0;
    logic [2:0]  rd_word = '0;
    logic [31:0] rd_data;
    logic        trig = 1'b0;
    logic        req_valid, req_ack;
    logic [31:0] req_src, req_dst;
    logic [15:0] req_bytes;
    logic [5:0]  req_beat_bytes;
    logic        req_src_const, req_dst_const;
    logic        busy, trig_err, cmp_int, cmp_chain, cmp_final;
    logic [5:0]  cmp_code;

    logic ack_en = 1'b1;
    logic stall_en = 1'b0;
    logic stall = 1'b0;
    assign req_ack = ack_en && !stall;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int last_ack_cyc = 0;
    int err_seen = 0;
    bit done = 1'b0;

    logic [31:0] img [8][8];
    logic [79:0] exp_req [$];
    logic [10:0] exp_evt [$];

    dma3d_sequencer #(.N_SLOTS(8)) u_dma3d_sequencer (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
        .cfg_word(cfg_word), .cfg_wdata(cfg_wdata), .rd_slot(rd_slot),
        .rd_word(rd_word), .rd_data(rd_data), .trig(trig),
        .req_valid(req_valid), .req_ack(req_ack), .req_src(req_src),
        .req_dst(req_dst), .req_bytes(req_bytes), .req_beat_bytes(req_beat_bytes),
        .req_src_const(req_src_const), .req_dst_const(req_dst_const),
        .busy(busy), .trig_err(trig_err), .cmp_int(cmp_int),
        .cmp_chain(cmp_chain), .cmp_final(cmp_final), .cmp_code(cmp_code)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        stall <= stall_en ? !stall : 1'b0;
    end

    task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] sext(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    // Monitor: compare requests and completion pulses against the queues
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (req_valid && req_ack) begin
                last_ack_cyc = cyc;
                if (exp_req.size() == 0) begin
                    chk(1'b0, "R2/R11 unexpected request", {req_src, req_dst, req_bytes}, '0);
                end else begin
                    logic [79:0] e;
                    e = exp_req.pop_front();
                    chk({req_src, req_dst, req_bytes} == e, "R2/R3/R4 request",
                        {req_src, req_dst, req_bytes}, e);
                end
            end
            if (cmp_int || cmp_chain) begin
                logic [10:0] a;
                a = {cmp_int, cmp_chain, cmp_final, cmp_code, 2'(cyc - last_ack_cyc)};
                if (exp_evt.size() == 0) begin
                    chk(1'b0, "R9 unexpected completion", a, '0);
                end else begin
                    logic [10:0] e;
                    e = exp_evt.pop_front();
                    chk(a == e, "R9/R10 completion {int,chain,final,code,delay}", a, e);
                end
            end
            if (trig_err) err_seen++;
        end
    end

    task automatic wr(input int s, input int w, input logic [31:0] v);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_slot = 3'(s); cfg_word = 3'(w); cfg_wdata = v;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        img[s][w] = v;
    endtask

    task automatic load_desc(input int s, input logic [31:0] o, input logic [31:0] sa,
                             input logic [31:0] ab, input logic [31:0] da, input logic [31:0] bs,
                             input logic [31:0] lk, input logic [31:0] cs, input logic [31:0] cc);
        wr(s, 0, o); wr(s, 1, sa); wr(s, 2, ab); wr(s, 3, da);
        wr(s, 4, bs); wr(s, 5, lk); wr(s, 6, cs); wr(s, 7, cc);
    endtask

    task automatic pulse_trig();
        @(posedge clk); #1 trig = 1'b1;
        @(posedge clk); #1 trig = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 4) begin
            @(posedge clk); #1;
            quiet = busy ? 0 : quiet + 1;
        end
    endtask

    task automatic check_slot0(input string tag);
        for (int w = 0; w < 8; w++) begin
            rd_slot = 3'd0; rd_word = 3'(w); #1;
            chk(rd_data == img[0][w], tag, rd_data, img[0][w]);
        end
    endtask

    // Reference model of one trigger service, written from the requirements
    task automatic model_service();
        logic [31:0] o, s, d, sb, db, sc, dc;
        logic [15:0] acnt, b, c, rld, lnk, bfull;
        bit fr, fin, ei, ec;
        int n;
        o = img[0][0]; s = img[0][1]; d = img[0][3];
        acnt = img[0][2][15:0]; b = img[0][2][31:16]; bfull = b;
        c = img[0][7][15:0]; rld = img[0][5][31:16]; lnk = img[0][5][15:0];
        sb = sext(img[0][4][15:0]); db = sext(img[0][4][31:16]);
        sc = sext(img[0][6][15:0]); dc = sext(img[0][6][31:16]);
        fr = o[2];
        n = fr ? int'(b) : 1;
        for (int i = 0; i < n; i++) begin
            exp_req.push_back({s, d, acnt});
            if (b > 16'd1) begin
                b--;
                if (!o[0]) s += sb;
                if (!o[1]) d += db;
            end else begin
                c--;
                if (!o[0]) s += sc;
                if (!o[1]) d += dc;
                b = fr ? bfull : rld;
            end
        end
        fin = (c == 16'd0);
        ei = fin ? o[20] : o[21];
        ec = fin ? o[22] : o[23];
        if (ei || ec) exp_evt.push_back({ei, ec, fin, o[17:12], o[11] ? 2'd1 : 2'd2});
        if (!o[3]) begin
            if (fin && lnk < 16'd8) begin
                logic [15:0] k;
                k = lnk;
                for (int w = 0; w < 8; w++) img[0][w] = img[k[2:0]][w];
            end else begin
                img[0][1] = s;
                img[0][3] = d;
                img[0][2] = fin ? 32'd0 : {b, acnt};
                img[0][7][15:0] = fin ? 16'd0 : c;
            end
        end
    endtask

    initial begin
        int e0;
        for (int s = 0; s < 8; s++) for (int w = 0; w < 8; w++) img[s][w] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(!busy && !req_valid && !trig_err, "R1 control outputs", {busy, req_valid, trig_err}, 0);
        chk(!cmp_int && !cmp_chain && !cmp_final, "R1 completion outputs", {cmp_int, cmp_chain, cmp_final}, 0);
        check_slot0("R1 slot 0 cleared");

        // R2/R4/R5/R9: array sync, signed strides, stalled acks, then null link (R7)
        load_desc(0, (32'd1 << 20) | (32'd1 << 21) | (32'd5 << 12), 32'h1000,
                  {16'd3, 16'd4}, 32'h2000, {16'd32, 16'd16},
                  {16'd3, 16'hFFFF}, {16'd100, 16'hFFF8}, 32'd2);
        stall_en = 1'b1;
        for (int t = 0; t < 6; t++) begin
            model_service();
            pulse_trig();
            wait_idle();
            check_slot0(t < 5 ? "R5 write-back after array" : "R7 null link clears counts");
        end
        stall_en = 1'b0;
        chk(!busy, "R7 busy low after null link", busy, 0);

        // R11: trigger with zero counts
        e0 = err_seen;
        pulse_trig();
        wait_idle();
        chk(err_seen == e0 + 1, "R11 error pulse count", err_seen, e0 + 1);
        check_slot0("R11 slot untouched by refused trigger");

        // R3/R6: frame sync, chain enables, link to slot 3
        load_desc(3, (32'd1 << 0) | (32'd1 << 11) | (32'd1 << 20) | (32'd1 << 21) | (32'd33 << 12) | (32'd2 << 8),
                  32'h8000, {16'd1, 16'd8}, 32'h9000, {16'd4, 16'd4},
                  {16'd1, 16'hFFFF}, {16'd12, 16'd12}, 32'd2);
        load_desc(0, (32'd1 << 2) | (32'd1 << 22) | (32'd1 << 23) | (32'd9 << 12), 32'h100,
                  {16'd2, 16'd16}, 32'h300, {16'h0040, 16'h0010},
                  {16'd7, 16'd3}, {16'hFFC0, 16'h0100}, 32'd2);
        for (int t = 0; t < 2; t++) begin
            model_service();
            pulse_trig();
            wait_idle();
            check_slot0(t == 0 ? "R3 frame sync write-back keeps BCNT" : "R6 linked slot copied");
        end

        // R4/R10/R13: constant source, early completion (linked-in descriptor)
        for (int t = 0; t < 2; t++) begin
            model_service();
            pulse_trig();
            wait_idle();
            check_slot0("R4 constant source write-back");
        end

        // R8: static descriptor is never rewritten
        load_desc(0, (32'd1 << 3) | (32'd1 << 20) | (32'd17 << 12), 32'h4000,
                  {16'd1, 16'd2}, 32'h5000, 32'd0, {16'd1, 16'd2}, 32'd0, 32'd1);
        for (int t = 0; t < 2; t++) begin
            model_service();
            pulse_trig();
            wait_idle();
            check_slot0("R8 static slot unchanged");
        end

        // R12/R13/R7: held trigger while stalled, out-of-range link
        load_desc(0, (32'd3 << 8) | (32'd1 << 1), 32'hA000,
                  {16'd2, 16'd4}, 32'hB000, {16'd8, 16'd8},
                  {16'd2, 16'h0010}, 32'd0, 32'd1);
        e0 = err_seen;
        model_service();
        model_service();
        ack_en = 1'b0;
        pulse_trig();
        pulse_trig();
        repeat (2) @(posedge clk);
        pulse_trig();
        #1;
        chk(req_valid && busy, "R12 first service stalled", {req_valid, busy}, 2'b11);
        chk(req_beat_bytes == 6'd8, "R13 beat bytes for code 3", req_beat_bytes, 8);
        chk(req_dst_const && !req_src_const, "R4 constant flags", {req_src_const, req_dst_const}, 2'b01);
        ack_en = 1'b1;
        wait_idle();
        check_slot0("R12 two services then R7 out-of-range link clears");
        chk(err_seen == e0, "R12 dropped trigger gives no error", err_seen, e0);
        chk(exp_req.size() == 0, "R12 all expected requests seen", exp_req.size(), 0);
        chk(exp_evt.size() == 0, "R9 all expected completions seen", exp_evt.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule